// File: doc/BRIEF.md
# Read Timing Calibration Sequencer

This block searches, in hardware, for a read sampling setting that works at each serial flash clock rate a memory controller can use. It drives an external checksum engine: each request names a clock divisor code and a 4-bit delay nibble, and the engine answers with the checksum of a fixed flash region read under those settings. The first request, at the slowest clock with no delay, gives the reference checksum. Every later answer is compared with it.

After the reference is taken, the sequencer walks the divisors from slowest to fastest. It skips any divisor below the allowed minimum. For each divisor it increases the hold-cycle count until a setting reads correctly both with and without the fine delay flag. The accepted nibble for each divisor is packed into a timing compensation word, and the whole word is written out once when the search ends. While the search runs, chip-select 0 is held in fast-read mode. It is returned to its cleared state when the search finishes.

Top module: `calib_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ck_req_o`, `timing_we_o` and `cs0_fast_o` are 0, and `timing_o` is 0.
- R2: The first request of every run uses divisor code 0 and delay 0, and it is issued while `cs0_fast_o` is 0.
- R3: After the reference, divisors are tried in the order 5, 4, 3, 2, 1, encoded as codes 13, 6, 14, 7, 15. A divisor below `min_div_i` gets no request. The values 0 and 1 of `min_div_i` skip nothing.
- R4: For each tried divisor, the hold count goes from 0 up to 5. Each count is first requested with delay bit 3 set and bits 2:0 equal to the count. A mismatching answer moves on to the next count.
- R5: When the flagged try matches, the same count is requested again with bit 3 clear. A match accepts the count and ends that divisor. A mismatch moves on to the next count. No divisor gets requests after its count 5.
- R6: The accepted count for divisor d is stored as the nibble {0, count} at bits 4·(d−1)+3 : 4·(d−1) of `timing_o`. A divisor that is skipped, or that never passes, leaves its nibble at 0.
- R7: `timing_o` changes only in the single cycle in which `timing_we_o` is high. This happens once per run, after the last answer.
- R8: While `cs0_fast_o` is 1, `cs0_opcode_o` is 0x0B and `cs0_dummy_o` is 1. `cs0_fast_o` rises after the reference answer and falls with the timing write. Once it is low, both fields are 0.
- R9: `done_o` is high for exactly the one cycle after `timing_we_o`. A `start_i` pulse while `busy_o` is high has no effect.
- R10: At most one request is outstanding. `ck_req_o` is a one-cycle pulse, and no new pulse is issued before `ck_ack_i` answers the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a calibration run when idle |
| min_div_i | input | DIV_W | Smallest divisor allowed |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ck_req_o | output | 1 | Checksum request pulse |
| ck_div_o | output | 4 | Divisor code of the request |
| ck_delay_o | output | 4 | Delay nibble of the request |
| ck_ack_i | input | 1 | Checksum answer valid |
| ck_sum_i | input | SUM_W | Checksum answer |
| cs0_fast_o | output | 1 | Chip-select 0 in fast-read mode |
| cs0_opcode_o | output | 8 | Chip-select 0 read opcode |
| cs0_dummy_o | output | 3 | Chip-select 0 dummy byte count |
| timing_o | output | TIM_W | Packed timing compensation word |
| timing_we_o | output | 1 | Timing word write strobe |

## Verification
The assertions assume that the checksum engine answers each request exactly once, with a one-cycle `ck_ack_i` pulse at least one cycle after the request, and never answers when nothing is outstanding. The bench engine model keeps to this rule. It waits a latency of one to three cycles after each observed request, raises the answer for one cycle, and then goes back to watching the request line. Its pass/fail answers come from per-divisor thresholds for the flagged and unflagged tries. These thresholds are swept with every minimum divisor, so the bench covers early passes, late passes, flag-only passes and divisors that never pass.

// File: rtl/calib_seq.sv
module calib_seq #(
  parameter int SUM_W    = 32,
  parameter int NUM_DIV  = 5,
  parameter int HOLD_MAX = 5,
  localparam int DIV_W   = $clog2(NUM_DIV + 1),
  localparam int TIM_W   = 4 * NUM_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] min_div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ck_req_o,
  output logic [3:0]       ck_div_o,
  output logic [3:0]       ck_delay_o,
  input  logic             ck_ack_i,
  input  logic [SUM_W-1:0] ck_sum_i,
  output logic             cs0_fast_o,
  output logic [7:0]       cs0_opcode_o,
  output logic [2:0]       cs0_dummy_o,
  output logic [TIM_W-1:0] timing_o,
  output logic             timing_we_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_REF_REQ, S_REF_WAIT, S_DIV, S_TRY_REQ, S_TRY_WAIT, S_COMMIT, S_FINISH
  } state_t;

  state_t           state;
  logic [DIV_W-1:0] div;
  logic [2:0]       hold;
  logic             flag;
  logic [SUM_W-1:0] gold;
  logic [TIM_W-1:0] acc;
  logic             fast_q, we_q, done_q;

  function automatic logic [3:0] div_code(input logic [DIV_W-1:0] d);
    int k;
    k = int'(d);
    if (d[0]) return 4'(15 - (k - 1) / 2);
    else      return 4'(7 - (k - 2) / 2);
  endfunction

  wire match    = (ck_sum_i == gold);
  wire last_div = (div == DIV_W'(1));
  wire ref_req  = (state == S_REF_REQ);

  assign busy_o       = (state != S_IDLE);
  assign done_o       = done_q;
  assign timing_we_o  = we_q;
  assign ck_req_o     = ref_req || (state == S_TRY_REQ);
  assign ck_div_o     = ref_req ? 4'd0 : div_code(div);
  assign ck_delay_o   = ref_req ? 4'd0 : {flag, hold};
  assign cs0_fast_o   = fast_q;
  assign cs0_opcode_o = fast_q ? 8'h0B : 8'h00;
  assign cs0_dummy_o  = fast_q ? 3'd1 : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div      <= '0;
      hold     <= '0;
      flag     <= 1'b0;
      gold     <= '0;
      acc      <= '0;
      timing_o <= '0;
      fast_q   <= 1'b0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_IDLE:
          if (start_i) begin
            acc   <= '0;
            div   <= DIV_W'(NUM_DIV);
            state <= S_REF_REQ;
          end
        S_REF_REQ: state <= S_REF_WAIT;
        S_REF_WAIT:
          if (ck_ack_i) begin
            gold   <= ck_sum_i;
            fast_q <= 1'b1;
            state  <= S_DIV;
          end
        S_DIV:
          if (div < min_div_i) begin
            if (last_div) state <= S_COMMIT;
            else          div   <= div - 1'b1;
          end else begin
            hold  <= '0;
            flag  <= 1'b1;
            state <= S_TRY_REQ;
          end
        S_TRY_REQ: state <= S_TRY_WAIT;
        S_TRY_WAIT:
          if (ck_ack_i) begin
            if (match && flag) begin
              flag  <= 1'b0;
              state <= S_TRY_REQ;
            end else if (match || hold == 3'(HOLD_MAX)) begin
              if (match)
                for (int i = 0; i < NUM_DIV; i++)
                  if (int'(div) == i + 1) acc[4*i +: 4] <= {1'b0, hold};
              if (last_div) state <= S_COMMIT;
              else begin
                div   <= div - 1'b1;
                state <= S_DIV;
              end
            end else begin
              hold  <= hold + 1'b1;
              flag  <= 1'b1;
              state <= S_TRY_REQ;
            end
          end
        S_COMMIT: begin
          timing_o <= acc;
          we_q     <= 1'b1;
          fast_q   <= 1'b0;
          state    <= S_FINISH;
        end
        S_FINISH: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/calib_seq_chk.sv
module calib_seq_chk #(
  parameter int TIM_W    = 20,
  parameter int HOLD_MAX = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             ck_req_o,
  input logic [3:0]       ck_div_o,
  input logic [3:0]       ck_delay_o,
  input logic             ck_ack_i,
  input logic             cs0_fast_o,
  input logic [7:0]       cs0_opcode_o,
  input logic [2:0]       cs0_dummy_o,
  input logic [TIM_W-1:0] timing_o,
  input logic             timing_we_o
);

  logic pending;
  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= 1'b0;
    else if (ck_req_o) pending <= 1'b1;
    else if (ck_ack_i) pending <= 1'b0;
  end

  p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ck_req_o |-> !pending);
  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ck_req_o |=> !ck_req_o);
  p_ref_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_req_o && !cs0_fast_o) |-> (ck_div_o == 4'd0 && ck_delay_o == 4'd0));
  p_sweep_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_req_o && cs0_fast_o) |-> (ck_div_o != 4'd0));
  p_hold_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ck_req_o |-> (ck_delay_o[2:0] <= 3'(HOLD_MAX)));
  p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timing_we_o |=> !timing_we_o);
  p_timing_only_on_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_o != $past(timing_o)) |-> timing_we_o);
  p_cs0_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs0_fast_o |-> (cs0_opcode_o == 8'h0B && cs0_dummy_o == 3'd1));
  p_cs0_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs0_fast_o |-> (cs0_opcode_o == 8'h00 && cs0_dummy_o == 3'd0));
  p_done_after_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(timing_we_o));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ck_req_o);

endmodule

bind calib_seq calib_seq_chk #(.TIM_W(TIM_W), .HOLD_MAX(HOLD_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .ck_req_o(ck_req_o), .ck_div_o(ck_div_o), .ck_delay_o(ck_delay_o),
  .ck_ack_i(ck_ack_i), .cs0_fast_o(cs0_fast_o), .cs0_opcode_o(cs0_opcode_o),
  .cs0_dummy_o(cs0_dummy_o), .timing_o(timing_o), .timing_we_o(timing_we_o)
);

// File: tb/tb_calib_seq.sv
module tb_calib_seq;
  localparam logic [31:0] GOLD = 32'hA5C3_0F17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  min_div_i = '0;
  logic        ck_ack_i = 1'b0;
  logic [31:0] ck_sum_i = '0;
  logic        busy_o, done_o, ck_req_o, cs0_fast_o, timing_we_o;
  logic [3:0]  ck_div_o, ck_delay_o;
  logic [7:0]  cs0_opcode_o;
  logic [2:0]  cs0_dummy_o;
  logic [19:0] timing_o;

  calib_seq dut (.*);

  always #10 clk = ~clk;

  int checks = 0, bad = 0;
  int reqs, last_d, lat, mind;
  int a_thr [1:5];
  int b_thr [1:5];
  bit summarized = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int code_to_div(input logic [3:0] c);
    case (c)
      4'd13: return 5;
      4'd6:  return 4;
      4'd14: return 3;
      4'd7:  return 2;
      4'd15: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic serve();
    int d, h;
    bit pass;
    reqs++;
    d = code_to_div(ck_div_o);
    h = int'(ck_delay_o[2:0]);
    if (reqs == 1) begin
      chk(ck_div_o == 4'd0 && ck_delay_o == 4'd0 && !cs0_fast_o, "R2 reference request",
          {ck_div_o, ck_delay_o}, 0);
      pass = 1;
    end else begin
      chk(cs0_fast_o && cs0_opcode_o == 8'h0B && cs0_dummy_o == 3'd1, "R8 fast read during sweep",
          {cs0_fast_o, cs0_opcode_o, cs0_dummy_o}, {1'b1, 8'h0B, 3'd1});
      chk(d >= 1 && d >= mind && d <= last_d, "R3 divisor order and skip", d, last_d);
      chk(h <= 5, "R4 hold range", h, 5);
      last_d = d;
      if (d >= 1) pass = ck_delay_o[3] ? (h >= a_thr[d]) : (h >= b_thr[d]);
      else        pass = 0;
    end
    repeat (lat) @(negedge clk);
    ck_sum_i = pass ? GOLD : (GOLD ^ 32'h0000_0100);
    ck_ack_i = 1'b1;
    @(negedge clk);
    ck_ack_i = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    forever begin
      if (ck_req_o === 1'b1) serve();
      else @(negedge clk);
    end
  end

  task automatic finish_up();
    if (!summarized) begin
      summarized = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  task automatic run_case(input int md, input int p, input int l);
    logic [19:0] exp_t, prev_t;
    int exp_req, m, cyc;
    bit seen, stable_ok;
    mind = md; lat = l;
    for (int d = 1; d <= 5; d++) begin
      a_thr[d] = (d * 3 + p * 2) % 8;
      b_thr[d] = (d + p * 5) % 7;
    end
    exp_t = '0;
    exp_req = 1;
    for (int d = 5; d >= 1; d--) begin
      if (d < md) continue;
      m = (a_thr[d] > b_thr[d]) ? a_thr[d] : b_thr[d];
      if (m <= 5) exp_t[4*(d-1) +: 4] = 4'(m);
      for (int h = 0; h <= 5; h++) begin
        if (h < a_thr[d]) exp_req += 1;
        else begin
          exp_req += 2;
          if (h >= b_thr[d]) break;
        end
      end
    end
    min_div_i = 3'(md);
    reqs = 0; last_d = 6;
    prev_t = timing_o;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R9 busy after start", busy_o, 1);
    seen = 0; stable_ok = 1; cyc = 0;
    while (!seen && cyc < 2000) begin
      if (timing_we_o) seen = 1;
      else begin
        if (timing_o !== prev_t) stable_ok = 0;
        start_i = (cyc == 3);
        @(negedge clk);
        start_i = 1'b0;
        cyc++;
      end
    end
    chk(stable_ok && seen, "R7 timing held until write", timing_o, prev_t);
    chk(timing_o == exp_t, "R6 packed timing word", timing_o, exp_t);
    chk(!cs0_fast_o && cs0_opcode_o == 8'h00 && cs0_dummy_o == 3'd0, "R8 cs0 cleared",
        {cs0_fast_o, cs0_opcode_o, cs0_dummy_o}, 0);
    @(negedge clk);
    chk(!timing_we_o && done_o && !busy_o, "R9 done one cycle after write",
        {timing_we_o, done_o, busy_o}, 3'b010);
    @(negedge clk);
    chk(!done_o, "R9 done is a pulse", done_o, 0);
    repeat (6) @(negedge clk);
    chk(!busy_o && timing_o == exp_t, "R9 start while busy ignored", busy_o, 0);
    chk(reqs == exp_req, "R5 request count", reqs, exp_req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !ck_req_o && !timing_we_o && !cs0_fast_o && timing_o == '0,
        "R1 reset state", {busy_o, done_o, ck_req_o, timing_we_o, cs0_fast_o}, 0);
    for (int md = 0; md <= 5; md++)
      for (int p = 0; p < 4; p++)
        run_case(md, p, 1 + (p % 3));
    finish_up();
  end
endmodule